// File: doc/BRIEF.md
# Gain-Aware Dither Generator with Saturation Guard

This block supplies a pseudo-random dither word to a single-bit delta-sigma modulator whose loop gain can be switched in 2 dB steps. On each sample strobe it advances a maximal-length shift register and scales part of its state into a signed, uniformly distributed fixed-point word. The width of that word's range depends on the current gain code: it is wide at low gain and narrow at high gain.

The block also watches the modulator's own output stream. It keeps the four most recent output bits. Dither is allowed only while that window shows a strictly alternating pattern. Any two neighbouring bits that are equal are taken as a sign that the loop is moving toward saturation. The enable decision is registered and applies from the next sample on. While dither is off, the output word is held at zero, but the random source keeps advancing.

Top module: `gain_dither_gen`

## Requirements
- R1: While `rst_n` is low, `dither_out` is 0 and `dither_en` is 0. The random register is loaded with 16'hACE1 and the output-bit window is emptied.
- R2: The random source is a 16-bit Fibonacci shift register with polynomial x^16+x^15+x^13+x^4+1. On each advance it shifts toward the MSB, and bit 0 receives the XOR of bits 15, 14, 12 and 3. It advances exactly once per clock in which `smp_stb` is high, whether dither is enabled or not.
- R3: On a strobe, r is taken as the low 8 bits of the register after that strobe's advance. The dither word is floor(r*A/256) - A/2, in two's complement with 8 fractional bits per quantizer LSB. For gain codes 0 to 6 (0 to 12 dB), A = 146 (0.57 LSB). For codes 7 to 10 (14 to 20 dB), A = 64 (0.25 LSB).
- R4: Gain codes 11 to 15 lie outside the 0 to 20 dB range and use the narrow amplitude, A = 64.
- R5: The window holds the four most recent `mod_bit` values captured on strobes. On strobe k, `dither_en` is set high when samples k-4 to k-1 are all present and no two neighbours among them are equal, that is, 0101 or 1010.
- R6: When any neighbouring pair in that window is equal, the strobe sets `dither_en` to 0 and `dither_out` to 0.
- R7: After reset, `dither_en` stays 0 through the first four strobes. The fifth strobe is the earliest one that can enable dither.
- R8: `dither_out` and `dither_en` change only on a clock edge with `smp_stb` high. Changes on `mod_bit` and `gain_code` between strobes have no effect on them.
- R9: `dither_out` always lies between -73 and +72. With the narrow amplitude, it lies between -32 and +31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| mod_bit | input | 1 | Modulator output bit for this sample |
| gain_code | input | 4 | Loop gain code, 2 dB per step |
| dither_out | output | 10 | Signed dither word, 8 fractional bits |
| dither_en | output | 1 | Dither injection enabled |

## Verification
The hardest state to reach is a window that is full and strictly alternating, with the gain code exactly on the amplitude boundary (6 versus 7) at the strobe. Only then does the amplitude choice become visible at the output. The stimulus first feeds four alternating bits after reset, then sweeps the gain code while the bits keep alternating. It then inserts a single repeated bit to show that dither shuts off on the next sample and stays off until the window alternates again. A reset in the middle of a run checks that the four-sample fill requirement applies again.

// File: rtl/dither_pkg.sv
package dither_pkg;
  localparam int DITH_FRAC_W  = 8;
  localparam int DITH_OUT_W   = DITH_FRAC_W + 2;
  localparam int DITH_AMP_W   = DITH_FRAC_W + 1;
  localparam int DITH_PROD_W  = 2 * DITH_FRAC_W + 1;
  localparam int AMP_WIDE     = (57 * (1 << DITH_FRAC_W) + 50) / 100;
  localparam int AMP_NARROW   = (1 << DITH_FRAC_W) / 4;
  localparam int GAIN_WIDE_MAX = 6;

  typedef logic [DITH_AMP_W-1:0]        amp_t;
  typedef logic signed [DITH_OUT_W-1:0] dith_t;

  function automatic amp_t amp_for_gain(input logic [3:0] code);
    return (int'(code) <= GAIN_WIDE_MAX) ? amp_t'(AMP_WIDE) : amp_t'(AMP_NARROW);
  endfunction

  function automatic dith_t dither_scale(input logic [DITH_FRAC_W-1:0] r, input amp_t amp);
    logic [DITH_PROD_W-1:0] prod;
    logic [DITH_OUT_W-1:0]  mag;
    logic [DITH_OUT_W-1:0]  half;
    prod = DITH_PROD_W'(r) * DITH_PROD_W'(amp);
    mag  = DITH_OUT_W'(prod >> DITH_FRAC_W);
    half = DITH_OUT_W'(amp >> 1);
    return dith_t'(mag - half);
  endfunction
endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
  parameter int              LFSR_W = 16,
  parameter int              OUT_W  = 8,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [OUT_W-1:0] rand_next
);
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] nxt;
  logic              fb;

  assign fb        = state[15] ^ state[14] ^ state[12] ^ state[3];
  assign nxt       = {state[LFSR_W-2:0], fb};
  assign rand_next = nxt[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= nxt;
  end

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  assert_lfsr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(adv) |-> $stable(state));
endmodule

// File: rtl/dither_history.sv
module dither_history #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic bit_in,
  output logic win_full,
  output logic win_ok
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] hist;
  logic [CNT_W-1:0] fill;
  logic [DEPTH-2:0] differs;

  generate
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_pair
      assign differs[i] = hist[i] ^ hist[i+1];
    end
  endgenerate

  assign win_full = (fill == CNT_W'(DEPTH));
  assign win_ok   = win_full && (&differs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      fill <= '0;
    end else if (push) begin
      hist <= {hist[DEPTH-2:0], bit_in};
      if (!win_full) fill <= fill + 1'b1;
    end
  end

  assert_fill_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));
endmodule

// File: rtl/dither_amp_sel.sv
module dither_amp_sel
  import dither_pkg::*;
(
  input  logic [3:0]             gain_code,
  input  logic [DITH_FRAC_W-1:0] rand_word,
  output dith_t                  scaled
);
  amp_t amp;
  assign amp    = amp_for_gain(gain_code);
  assign scaled = dither_scale(rand_word, amp);
endmodule

// File: rtl/gain_dither_gen.sv
module gain_dither_gen
  import dither_pkg::*;
#(
  parameter int HIST_DEPTH = 4,
  parameter int LFSR_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_stb,
  input  logic                         mod_bit,
  input  logic [3:0]                   gain_code,
  output logic signed [DITH_OUT_W-1:0] dither_out,
  output logic                         dither_en
);
  localparam int WIDE_HALF = AMP_WIDE / 2;
  localparam int NARR_HALF = AMP_NARROW / 2;

  logic [DITH_FRAC_W-1:0] rand_word;
  logic                   win_full;
  logic                   win_ok;
  dith_t                  scaled;

  dither_lfsr #(.LFSR_W(LFSR_W), .OUT_W(DITH_FRAC_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(smp_stb), .rand_next(rand_word));

  dither_history #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(smp_stb), .bit_in(mod_bit),
    .win_full(win_full), .win_ok(win_ok));

  dither_amp_sel u_amp (.gain_code(gain_code), .rand_word(rand_word), .scaled(scaled));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dither_en  <= 1'b0;
      dither_out <= '0;
    end else if (smp_stb) begin
      dither_en  <= win_ok;
      dither_out <= win_ok ? scaled : '0;
    end
  end

  assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dither_en |-> dither_out == '0);
  assert_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dither_out >= -DITH_OUT_W'(WIDE_HALF)) && (dither_out < DITH_OUT_W'(WIDE_HALF)));
  assert_narrow_amp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smp_stb) && (int'($past(gain_code)) > GAIN_WIDE_MAX) && dither_en) |->
    ((dither_out >= -DITH_OUT_W'(NARR_HALF)) && (dither_out < DITH_OUT_W'(NARR_HALF))));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_stb) |-> ($stable(dither_out) && $stable(dither_en)));
  assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smp_stb) && !$past(win_full)) |-> !dither_en);
endmodule

// File: tb/gain_dither_gen_bench.sv
module gain_dither_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_stb = 1'b0;
  logic              mod_bit = 1'b0;
  logic [3:0]        gain_code = 4'd0;
  logic signed [9:0] dither_out;
  logic              dither_en;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int m_lfsr;
  int m_hist[$];
  int m_out;
  int m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_dither_gen u_gain_dither_gen (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mod_bit(mod_bit),
    .gain_code(gain_code), .dither_out(dither_out), .dither_en(dither_en));

  task automatic model_reset();
    m_lfsr = 16'hACE1;
    m_hist.delete();
    m_out = 0;
    m_en = 0;
  endtask

  task automatic model_strobe(input int b, input int g);
    int fb, r, a, alt;
    alt = (m_hist.size() == 4) ? 1 : 0;
    for (int i = 0; i + 1 < m_hist.size(); i++)
      if (m_hist[i] == m_hist[i+1]) alt = 0;
    fb = ((m_lfsr >> 15) ^ (m_lfsr >> 14) ^ (m_lfsr >> 12) ^ (m_lfsr >> 3)) & 1;
    m_lfsr = ((m_lfsr << 1) | fb) & 16'hFFFF;
    r = m_lfsr % 256;
    a = (g <= 6) ? 146 : 64;
    m_en = alt;
    m_out = alt ? ((r * a) / 256 - a / 2) : 0;
    m_hist.push_back(b);
    if (m_hist.size() > 4) void'(m_hist.pop_front());
  endtask

  task automatic compare();
    checks++;
    if (int'(dither_out) != m_out) begin
      errors++;
      $display("FAIL %s dither_out actual=%0d expected=%0d", cur_req, dither_out, m_out);
    end
    checks++;
    if (int'(dither_en) != m_en) begin
      errors++;
      $display("FAIL %s dither_en actual=%0d expected=%0d", cur_req, dither_en, m_en);
    end
  endtask

  task automatic step(input bit stb, input bit b, input int g);
    smp_stb = stb;
    mod_bit = b;
    gain_code = 4'(g);
    @(posedge clk);
    #2;
    if (stb && rst_n) model_strobe(int'(b), g);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_stb = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R7: the first four strobes never enable, even with alternating bits
    cur_req = "R7";
    for (int k = 0; k < 4; k++) step(1'b1, 1'(k % 2), 2);
    // R5 R3 R2: alternating window, wide amplitude codes 0..6
    cur_req = "R5";
    for (int k = 0; k < 40; k++) step(1'b1, 1'(k % 2), k % 7);
    // R3: boundary codes 6 and 7 and the top code 10
    cur_req = "R3";
    for (int k = 0; k < 30; k++) step(1'b1, 1'(k % 2), (k % 3 == 0) ? 6 : ((k % 3 == 1) ? 7 : 10));
    // R4: out-of-range codes use the narrow amplitude
    cur_req = "R4";
    for (int k = 0; k < 25; k++) step(1'b1, 1'(k % 2), 11 + (k % 5));
    // R6: constant bits disable, LFSR keeps running (R2 visible after re-enable)
    cur_req = "R6";
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 3);
    cur_req = "R2";
    for (int k = 0; k < 12; k++) step(1'b1, 1'(k % 2), 3);
    // R6: a single repeated bit inside an alternating run
    cur_req = "R6";
    for (int k = 0; k < 20; k++) step(1'b1, (k == 9) ? 1'b0 : 1'(k % 2), 5);
    // R8: no strobe, inputs wiggle, outputs must hold
    cur_req = "R8";
    for (int k = 0; k < 20; k++) step(1'b0, 1'(k % 2), k % 16);
    for (int k = 0; k < 30; k++) begin
      step(1'b1, 1'(k % 2), 1);
      step(1'b0, 1'((k + 1) % 2), 9);
      step(1'b0, 1'b1, 0);
    end
    // R9: long run at both amplitudes with strobe gaps
    cur_req = "R9";
    for (int k = 0; k < 600; k++) step(1'(k % 3 != 2), 1'(k % 2), (k / 50) % 11);
    // R1 R7: reset mid-run clears the window
    do_reset();
    cur_req = "R7";
    for (int k = 0; k < 4; k++) step(1'b1, 1'(k % 2), 0);
    cur_req = "R5";
    for (int k = 0; k < 10; k++) step(1'b1, 1'(k % 2), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule